// File: doc/BRIEF.md
# Converter Serial Configuration and Status Port

This block is the four-wire serial slave that sits in front of a data converter. A host frames each transfer with an active-low chip select. On the data-in line it sends 16-bit instructions: a 4-bit address followed by 12 data bits, most significant bit first, sampled on rising serial-clock edges. The host can set up the auxiliary converter this way, picking the averaging count, the clock divider and whether results may be read. It can also kick off a conversion. The start bit is not stored. It turns into a single system-clock pulse toward the conversion sequencer.

The same port drives a shared data-out pin together with an output enable. While no transfer is reading, the pin shows status. It floats until a conversion is started. It is driven high while the sequencer reports busy, and driven low once the sequencer drops busy and the result word has been captured. When output mode is on, the next chip-select frame shifts the captured 10-bit result out MSB first, one bit per falling serial-clock edge, with zeros after it. When that frame ends the pin floats again. During a read the host holds data-in high, which forms an instruction to address 1111. No register lives at that address, so the instruction is dropped.

All serial pins are brought into the system clock through two-flop synchronizers, and their edges are detected there. The serial clock must therefore stay well below the system clock. The result word is taken from the sequencer on the cycle its busy flag falls. There is no back-pressure on that hand-off: the word must be valid on that cycle.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the data-out enable is low, no start pulse is issued, and averaging select, divider select and output mode are all zero.
- R2: A frame of exactly 16 bits addressed to the control register (address 0011, first four bits sent) loads averaging select from data bit 6:4, divider select from bits 9:7 and output mode from bit 10, where data bit 11 is the fifth bit sent and bit 0 the last. Register fields change only on such a write.
- R3: A frame with fewer or more than 16 serial clock rising edges changes no register and gives no start pulse.
- R4: A 16-bit instruction to address 1111 (for example data-in held high) or to any other unused address changes no register, gives no start pulse and leaves data-out as it was.
- R5: A committed control write with data bit 0 set produces exactly one start pulse, one system clock wide, and enables data-out driven high (busy). The start bit is not retained, so a later write with bit 0 clear gives no pulse.
- R6: When the busy input falls during a conversion, the result word is captured and data-out stays enabled but is driven low (ready).
- R7: With output mode 1 and a captured result, a chip-select falling edge starts a readout: data-out presents result bit 9 first and moves to the next bit on each serial clock falling edge. Once all 10 bits are out, zeros follow.
- R8: The chip-select rising edge that ends a readout frame disables data-out.
- R9: With output mode 0, a chip-select frame never places result data on data-out. The ready status (enabled, low) persists through and after the frame.
- R10: A later readout frame, with no new conversion in between, again starts from result bit 9.
- R11: A valid control write clocked in during a readout frame is committed while the result is shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Serial chip select, active low (asynchronous) |
| sclk_i | input | 1 | Serial clock, idle low (asynchronous) |
| din_i | input | 1 | Serial instruction data in (asynchronous) |
| busy_i | input | 1 | Conversion in progress, from the sequencer |
| result_i | input | 10 | Conversion result, valid when busy_i falls |
| dout_o | output | 1 | Data-out value |
| dout_oe_o | output | 1 | Data-out drive enable (0 = high impedance) |
| start_o | output | 1 | One-cycle conversion start pulse |
| avg_sel_o | output | 3 | Averaging select field |
| div_sel_o | output | 3 | Clock divider select field |
| out_mode_o | output | 1 | Result readout enabled |

## Verification
The hardest case to reach from the ports is a frame that does two things at once: it shifts a result out and also commits a new control write. For the result to exist, the frame must come after a full start, busy and capture sequence with output mode set. The bench sends a start, toggles busy with a known result, and then runs two read-only frames with data-in high to cover the address-1111 discard and the restart from bit 9. It then runs a 16-bit frame that carries a real write. A scoreboard queue holds the expected data-out bits, and a monitor compares them on each serial rising edge. The register fields are checked after the frame.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int SEL_W     = 3;
  localparam int START_BIT = 0;
  localparam int AVG_LSB   = 4;
  localparam int DIV_LSB   = 7;
  localparam int MODE_BIT  = 10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_READY = 2'd2,
    ST_DONE  = 2'd3
  } cfgp_state_e;

  typedef struct packed {
    logic             out_mode;
    logic [SEL_W-1:0] div_sel;
    logic [SEL_W-1:0] avg_sel;
  } cfgp_ctrl_t;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfgp_rx.sv
module cfgp_rx
  import cfgp_pkg::*;
#(
  parameter int             INSTR_W   = 16,
  parameter int             ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_low_i,
  input  logic       cs_fall_i,
  input  logic       cs_rise_i,
  input  logic       sclk_rise_i,
  input  logic       din_i,
  output logic       wr_o,
  output logic       start_req_o,
  output cfgp_ctrl_t ctrl_o,
  output logic       start_o
);
  localparam int DATA_W  = INSTR_W - ADDR_W;
  localparam int CNT_W   = $clog2(INSTR_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(INSTR_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(INSTR_W + 1);
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  logic [INSTR_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  data;
  logic               rsvd_unused;

  assign addr = sh_q[INSTR_W-1 -: ADDR_W];
  assign data = sh_q[DATA_W-1:0];
  assign rsvd_unused = ^{data[DATA_W-1:MODE_BIT+1], data[AVG_LSB-1:START_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (cs_fall_i) begin
      cnt_q <= '0;
    end else if (cs_low_i && sclk_rise_i) begin
      sh_q <= {sh_q[INSTR_W-2:0], din_i};
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wr_o = cs_rise_i && (cnt_q == CNT_FULL) &&
                (addr == CTRL_ADDR) && (addr != NULL_ADDR);
  assign start_req_o = wr_o && data[START_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o  <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= start_req_o;
      if (wr_o) begin
        ctrl_o.out_mode <= data[MODE_BIT];
        ctrl_o.div_sel  <= data[DIV_LSB +: SEL_W];
        ctrl_o.avg_sel  <= data[AVG_LSB +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/cfgp_tx.sv
module cfgp_tx
  import cfgp_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             out_mode_i,
  input  logic             start_req_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output cfgp_state_e      st_o,
  output logic             rd_active_o
);
  cfgp_state_e      st_q;
  logic             busy_q;
  logic             rd_q;
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] sh_q;
  logic             have_res;

  assign have_res = (st_q == ST_READY) || (st_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      res_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_i;
      if (start_req_i) begin
        st_q <= ST_BUSY;
        rd_q <= 1'b0;
      end else begin
        if (st_q == ST_BUSY && busy_q && !busy_i) begin
          res_q <= result_i;
          st_q  <= ST_READY;
        end
        if (cs_fall_i && out_mode_i && have_res) begin
          rd_q <= 1'b1;
          sh_q <= res_q;
        end else if (rd_q && sclk_fall_i) begin
          sh_q <= {sh_q[RES_W-2:0], 1'b0};
        end
        if (cs_rise_i && rd_q) begin
          rd_q <= 1'b0;
          st_q <= ST_DONE;
        end
      end
    end
  end

  assign dout_o      = rd_q ? sh_q[RES_W-1] : (st_q == ST_BUSY);
  assign dout_oe_o   = rd_q || (st_q == ST_BUSY) || (st_q == ST_READY);
  assign st_o        = st_q;
  assign rd_active_o = rd_q;
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int                INSTR_W     = 16,
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4'h3,
  parameter int                RES_W       = 10,
  parameter int                SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_i,
  input  logic             sclk_i,
  input  logic             din_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             start_o,
  output logic [SEL_W-1:0] avg_sel_o,
  output logic [SEL_W-1:0] div_sel_o,
  output logic             out_mode_o
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  logic cs_s, sclk_s, din_s;
  logic cs_p, sclk_p;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic cfg_wr, start_req, rd_active;
  cfgp_ctrl_t  ctrl;
  cfgp_state_e st;

  cfgp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_n_i, sclk_i, din_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, sclk_s, din_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= 1'b1;
      sclk_p <= 1'b0;
    end else begin
      cs_p   <= cs_s;
      sclk_p <= sclk_s;
    end
  end

  assign cs_fall   = cs_p && !cs_s;
  assign cs_rise   = !cs_p && cs_s;
  assign sclk_rise = !sclk_p && sclk_s;
  assign sclk_fall = sclk_p && !sclk_s;

  cfgp_rx #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_low_i    (!cs_s),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .sclk_rise_i (sclk_rise),
    .din_i       (din_s),
    .wr_o        (cfg_wr),
    .start_req_o (start_req),
    .ctrl_o      (ctrl),
    .start_o     (start_o)
  );

  cfgp_tx #(.RES_W(RES_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .sclk_fall_i (sclk_fall),
    .busy_i      (busy_i),
    .result_i    (result_i),
    .out_mode_i  (ctrl.out_mode),
    .start_req_i (start_req),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o),
    .st_o        (st),
    .rd_active_o (rd_active)
  );

  assign avg_sel_o  = ctrl.avg_sel;
  assign div_sel_o  = ctrl.div_sel;
  assign out_mode_o = ctrl.out_mode;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfgp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy_i,
  input logic             dout_o,
  input logic             dout_oe_o,
  input logic             start_o,
  input logic [SEL_W-1:0] avg_sel_o,
  input logic [SEL_W-1:0] div_sel_o,
  input logic             out_mode_o,
  input logic             cfg_wr,
  input logic             start_req,
  input logic             cs_rise,
  input logic             rd_active,
  input cfgp_state_e      st
);
  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (dout_oe_o && dout_o));

  // R6
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_i) && st == ST_BUSY && !start_req) |=> (dout_oe_o && !dout_o));

  // R8
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && rd_active && !start_req) |=> !dout_oe_o);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable({out_mode_o, div_sel_o, avg_sel_o}));
endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_i     (busy_i),
  .dout_o     (dout_o),
  .dout_oe_o  (dout_oe_o),
  .start_o    (start_o),
  .avg_sel_o  (avg_sel_o),
  .div_sel_o  (div_sel_o),
  .out_mode_o (out_mode_o),
  .cfg_wr     (cfg_wr),
  .start_req  (start_req),
  .cs_rise    (cs_rise),
  .rd_active  (rd_active),
  .st         (st)
);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, din = 1'b1, busy = 1'b0;
  logic [9:0] result = '0;
  logic       dout, dout_oe, start;
  logic [2:0] avg_sel, div_sel;
  logic       out_mode;

  int n_chk = 0, n_fail = 0;
  int start_cnt = 0;
  bit start_prev = 0, start_wide = 0;
  bit mon_on = 0, quiet_on = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
    .busy_i(busy), .result_i(result), .dout_o(dout), .dout_oe_o(dout_oe),
    .start_o(start), .avg_sel_o(avg_sel), .div_sel_o(div_sel), .out_mode_o(out_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] word, input int nbits);
    cs_n = 1'b0;
    cyc(H);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 16) ? word[15 - i] : 1'b1;
      cyc(H);
      sclk = 1'b1;
      cyc(H);
      sclk = 1'b0;
    end
    cyc(H);
    din  = 1'b1;
    cs_n = 1'b1;
    cyc(2 * H);
  endtask

  task automatic expect_bits(input logic [9:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(i < 10 ? v[9 - i] : 1'b0);
      tag_q.push_back(tag);
    end
  endtask

  task automatic conversion(input logic [9:0] v);
    busy = 1'b1;
    cyc(10);
    chk(dout_oe && dout, "R5 busy shown high", {dout_oe, dout}, 3);
    result = v;
    busy = 1'b0;
    cyc(4);
    result = '0;
    chk(dout_oe && !dout, "R6 ready shown low", {dout_oe, dout}, 2);
  endtask

  function automatic int fields();
    return {out_mode, div_sel, avg_sel};
  endfunction

  always @(negedge clk) begin
    if (start) start_cnt++;
    if (start && start_prev) start_wide = 1;
    start_prev = start;
  end

  // scoreboard monitor
  always @(posedge sclk) begin
    if (mon_on) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected readout bit", dout, 0);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(dout_oe && dout === e, t, {dout_oe, dout}, {1'b1, e});
      end
    end
    if (quiet_on)
      chk(dout_oe && !dout, "R9 no data in mode 0", {dout_oe, dout}, 2);
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(10);
    rst_n = 1'b1;
    cyc(5);
    chk(!dout_oe, "R1 dout disabled", dout_oe, 0);
    chk(fields() == 0, "R1 fields zero", fields(), 0);
    chk(start_cnt == 0, "R1 no start", start_cnt, 0);

    frame(16'h35D0, 16);
    chk(fields() == 7'h5D, "R2 fields loaded", fields(), 7'h5D);
    chk(start_cnt == 0, "R5 no pulse without start bit", start_cnt, 0);

    frame(16'h3000, 15);
    chk(fields() == 7'h5D, "R3 short frame discarded", fields(), 7'h5D);
    frame(16'h3000, 17);
    chk(fields() == 7'h5D, "R3 long frame discarded", fields(), 7'h5D);
    chk(start_cnt == 0, "R3 no start", start_cnt, 0);

    frame(16'hFFFF, 16);
    chk(fields() == 7'h5D, "R4 addr 1111 ignored", fields(), 7'h5D);
    frame(16'h5FFF, 16);
    chk(fields() == 7'h5D, "R4 unused addr ignored", fields(), 7'h5D);
    chk(start_cnt == 0, "R4 no start", start_cnt, 0);
    chk(!dout_oe, "R4 dout untouched", dout_oe, 0);

    frame(16'h35D1, 16);
    chk(start_cnt == 1, "R5 one start pulse", start_cnt, 1);
    chk(!start_wide, "R5 pulse one cycle", start_wide, 0);
    chk(dout_oe && dout, "R5 busy after start", {dout_oe, dout}, 3);
    chk(fields() == 7'h5D, "R5 fields kept", fields(), 7'h5D);

    conversion(10'h2D9);

    expect_bits(10'h2D9, 12, "R7 readout bit");
    mon_on = 1;
    frame(16'hFFFF, 12);
    mon_on = 0;
    chk(exp_q.size() == 0, "R7 all bits seen", exp_q.size(), 0);
    chk(fields() == 7'h5D, "R4 read frame harmless", fields(), 7'h5D);
    chk(!dout_oe, "R8 released after frame", dout_oe, 0);

    expect_bits(10'h2D9, 10, "R10 restart from MSB");
    mon_on = 1;
    frame(16'hFFFF, 10);
    mon_on = 0;
    chk(exp_q.size() == 0, "R10 all bits seen", exp_q.size(), 0);

    expect_bits(10'h2D9, 16, "R11 readout during write");
    mon_on = 1;
    frame(16'h35A0, 16);
    mon_on = 0;
    chk(exp_q.size() == 0, "R11 all bits seen", exp_q.size(), 0);
    chk(fields() == 7'h5A, "R11 write committed", fields(), 7'h5A);
    chk(!dout_oe, "R8 released after write frame", dout_oe, 0);
    chk(start_cnt == 1, "R5 start not retained", start_cnt, 1);

    frame(16'h31A1, 16);
    chk(start_cnt == 2, "R5 second start", start_cnt, 2);
    chk(fields() == 7'h1A, "R2 mode cleared", fields(), 7'h1A);
    conversion(10'h3FF);
    quiet_on = 1;
    frame(16'hFFFF, 12);
    quiet_on = 0;
    chk(dout_oe && !dout, "R9 ready kept after frame", {dout_oe, dout}, 2);
    chk(!start_wide, "R5 pulses one cycle", start_wide, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule